// File: doc/BRIEF.md
# Interprocessor Mailbox Message Controller

This block is a memory-mapped mailbox that lets several processors pass 32-bit words to one another. It holds six independent queues, each four words deep. A processor posts a word by writing the queue's message register and takes the oldest word by reading that same register. Each queue also has a read-only register that reports whether it is full and another that reports how many words it holds.

Four interrupt users share the queues. Each user has a status register and an enable register. For every queue these registers hold two event bits: a new-word event and a space-available event. Status bits are cleared by writing 1 to them. Each user drives one interrupt line, which is high when any of its status bits is set and also enabled.

The register bus is a single port. Addresses are byte addresses and all registers are 32 bits wide. Read data is registered and appears on the cycle after the read strobe. The block also has a fixed identification word, a configuration word with two writable bits, and a reset-complete indicator.

Top module: `mbox_hub`

## Requirements
- R1: A write to byte address 0x40+4n (n = 0..5) appends the word to queue n. A read of that address returns the oldest queued word and removes it. Read data appears on bus_rdata one cycle after the read strobe, and words come out in the order they were written.
- R2: A read of 0x80+4n returns 1 when queue n holds four words and returns 0 otherwise.
- R3: A read of 0xC0+4n returns the number of words in queue n, from 0 to 4.
- R4: A write to a queue that already holds four words is dropped. Its count and its contents do not change.
- R5: A read of an empty queue's message register returns 0 and changes no state. In particular, no status bit changes.
- R6: Every accepted write to queue n sets bit 2n of all four users' status registers.
- R7: A read that takes queue n from four words to three sets bit 2n+1 of all four users' status registers.
- R8: The status register of user u is at 0x100+8u, and bits 0..11 are meaningful. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: The enable register of user u is at 0x104+8u. Its bits 0..11 are read/write and reset to 0.
- R10: irq[u] is 1 exactly when (status AND enable) of user u was nonzero on the previous cycle. All irq lines are 0 after reset.
- R11: Address 0x00 reads the constant 0x00000021. Address 0x14 reads 1 once reset has completed. Address 0x10 keeps only bits 0 and 4 of a write and reads 0 after reset. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 4 | One interrupt line per user |

## Verification
Directed sequences come first. They overfill a single queue and then drain it past empty, which separates the dropped-write case from an accepted write and a zero-returning empty read from a real pop. The full-to-not-full transition is the only pop that raises the space-available bit. A long random mix of pushes, pops, status clears and enable changes then spreads traffic over all six queues and four users. This exposes crossed queue indices, wrong event-bit positions and interrupt lines that do not follow status AND enable a cycle later. A bench model of the queues and registers supplies every expected read value and interrupt level.

// File: rtl/mbox_hub.sv
module mbox_hub #(
  parameter int          NUM_BOX  = 6,
  parameter int          DEPTH    = 4,
  parameter int          NUM_USER = 4,
  parameter int          DW       = 32,
  parameter int          AW       = 9,
  parameter logic [31:0] REV_ID   = 32'h0000_0021
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [NUM_USER-1:0] irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = 2 * NUM_BOX;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] REV_ADDR = AW'('h000);
  localparam logic [AW-1:0] CFG_ADDR = AW'('h010);
  localparam logic [AW-1:0] SYS_ADDR = AW'('h014);
  localparam logic [AW-1:0] MSG_BASE = AW'('h040);
  localparam logic [AW-1:0] FST_BASE = AW'('h080);
  localparam logic [AW-1:0] CNT_BASE = AW'('h0C0);
  localparam logic [AW-1:0] USR_BASE = AW'('h100);
  localparam logic [DW-1:0] CFG_MASK = DW'('h11);

  logic [DW-1:0] mem [NUM_BOX][DEPTH];
  logic [PW-1:0] wp [NUM_BOX];
  logic [PW-1:0] rp [NUM_BOX];
  logic [CW-1:0] cnt [NUM_BOX];
  logic [SW-1:0] stat [NUM_USER];
  logic [SW-1:0] en [NUM_USER];
  logic [DW-1:0] cfg;
  logic          rst_done;
  logic [NUM_BOX-1:0] push, pop, pop_full, box_wsel, box_rsel;
  logic [SW-1:0] evt;
  logic [DW-1:0] rd_val;

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
    assign box_wsel[b] = bus_wr && (bus_addr == MSG_BASE + AW'(4 * b));
    assign box_rsel[b] = bus_rd && (bus_addr == MSG_BASE + AW'(4 * b));
    assign push[b]     = box_wsel[b] && (cnt[b] != FULL_CNT);
    assign pop[b]      = box_rsel[b] && (cnt[b] != '0);
    assign pop_full[b] = pop[b] && (cnt[b] == FULL_CNT);
    assign evt[2*b]    = push[b];
    assign evt[2*b+1]  = pop_full[b];

    always_ff @(posedge clk)
      if (push[b]) mem[b][wp[b]] <= bus_wdata;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp[b]  <= '0;
        rp[b]  <= '0;
        cnt[b] <= '0;
      end else begin
        if (push[b]) wp[b] <= (wp[b] == PW'(DEPTH - 1)) ? '0 : wp[b] + 1'b1;
        if (pop[b])  rp[b] <= (rp[b] == PW'(DEPTH - 1)) ? '0 : rp[b] + 1'b1;
        case ({push[b], pop[b]})
          2'b10:   cnt[b] <= cnt[b] + 1'b1;
          2'b01:   cnt[b] <= cnt[b] - 1'b1;
          default: cnt[b] <= cnt[b];
        endcase
      end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[b] <= FULL_CNT); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (box_wsel[b] && !bus_rd && cnt[b] == FULL_CNT) |=> (cnt[b] == FULL_CNT)); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (box_rsel[b] && !bus_wr && cnt[b] == '0) |=> (bus_rdata == '0 && cnt[b] == '0)); // R5
    AST_NEWMSG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      push[b] |=> stat[0][2*b]); // R6
    AST_NOTFULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_full[b] && !bus_wr) |=> (stat[NUM_USER-1][2*b+1] && cnt[b] == FULL_CNT - 1'b1)); // R7
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    logic st_sel, en_sel;
    assign st_sel = bus_wr && (bus_addr == USR_BASE + AW'(8 * u));
    assign en_sel = bus_wr && (bus_addr == USR_BASE + AW'(8 * u + 4));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[u] <= '0;
        en[u]   <= '0;
        irq[u]  <= 1'b0;
      end else begin
        stat[u] <= (stat[u] & ~(st_sel ? bus_wdata[SW-1:0] : '0)) | evt;
        if (en_sel) en[u] <= bus_wdata[SW-1:0];
        irq[u] <= |(stat[u] & en[u]);
      end
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat[u] & en[u]) == '0) |=> !irq[u]); // R10
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat[u] & en[u]) != '0) |=> irq[u]); // R10
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      rst_done <= 1'b0;
    end else begin
      rst_done <= 1'b1;
      if (bus_wr && bus_addr == CFG_ADDR) cfg <= bus_wdata & CFG_MASK;
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == REV_ADDR) rd_val = REV_ID;
    if (bus_addr == SYS_ADDR) rd_val = DW'(rst_done);
    if (bus_addr == CFG_ADDR) rd_val = cfg;
    for (int b = 0; b < NUM_BOX; b++) begin
      if (bus_addr == MSG_BASE + AW'(4 * b) && cnt[b] != '0) rd_val = mem[b][rp[b]];
      if (bus_addr == FST_BASE + AW'(4 * b)) rd_val = DW'(cnt[b] == FULL_CNT);
      if (bus_addr == CNT_BASE + AW'(4 * b)) rd_val = DW'(cnt[b]);
    end
    for (int u = 0; u < NUM_USER; u++) begin
      if (bus_addr == USR_BASE + AW'(8 * u))     rd_val = DW'(stat[u]);
      if (bus_addr == USR_BASE + AW'(8 * u + 4)) rd_val = DW'(en[u]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  AST_CFG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg & ~CFG_MASK) == '0); // R11
endmodule

// File: tb/tb_mbox_hub.sv
module tb_mbox_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_hub dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                .bus_rdata(bus_rdata), .irq(irq));

  logic [31:0] mq [6][$];
  logic [11:0] ms [4];
  logic [11:0] me [4];
  logic [31:0] mcfg;

  function automatic logic [3:0] model_irq();
    logic [3:0] r;
    for (int u = 0; u < 4; u++) r[u] = |(ms[u] & me[u]);
    return r;
  endfunction

  function automatic logic [31:0] model_read(logic [8:0] a);
    for (int b = 0; b < 6; b++) begin
      if (a == 9'h40 + 9'(4*b)) return (mq[b].size() != 0) ? mq[b][0] : 32'h0;
      if (a == 9'h80 + 9'(4*b)) return 32'(mq[b].size() == 4);
      if (a == 9'hC0 + 9'(4*b)) return 32'(mq[b].size());
    end
    for (int u = 0; u < 4; u++) begin
      if (a == 9'h100 + 9'(8*u)) return 32'(ms[u]);
      if (a == 9'h104 + 9'(8*u)) return 32'(me[u]);
    end
    if (a == 9'h000) return 32'h21;
    if (a == 9'h014) return 32'h1;
    if (a == 9'h010) return mcfg;
    return 32'h0;
  endfunction

  function automatic string req_of(logic [8:0] a);
    if (a >= 9'h40 && a < 9'h80) return "R1";
    if (a >= 9'h80 && a < 9'hC0) return "R2";
    if (a >= 9'hC0 && a < 9'h100) return "R3";
    if (a >= 9'h100) return a[2] ? "R9" : "R8";
    return "R11";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    logic [3:0] pre = model_irq();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int b = 0; b < 6; b++)
      if (a == 9'h40 + 9'(4*b) && mq[b].size() < 4) begin
        mq[b].push_back(d);
        for (int u = 0; u < 4; u++) ms[u][2*b] = 1'b1;
      end
    for (int u = 0; u < 4; u++) begin
      if (a == 9'h100 + 9'(8*u)) ms[u] = ms[u] & ~d[11:0];
      if (a == 9'h104 + 9'(8*u)) me[u] = d[11:0];
    end
    if (a == 9'h010) mcfg = d & 32'h11;
    chk("R10", 32'(irq), 32'(pre));
  endtask

  task automatic rd(logic [8:0] a, string req);
    logic [3:0]  pre = model_irq();
    logic [31:0] exp = model_read(a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
    for (int b = 0; b < 6; b++)
      if (a == 9'h40 + 9'(4*b) && mq[b].size() != 0) begin
        if (mq[b].size() == 4)
          for (int u = 0; u < 4; u++) ms[u][2*b+1] = 1'b1;
        void'(mq[b].pop_front());
      end
    chk("R10", 32'(irq), 32'(pre));
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    for (int u = 0; u < 4; u++) begin ms[u] = '0; me[u] = '0; end
    mcfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 32'(irq), 32'h0);
    rd(9'h000, "R11");
    rd(9'h014, "R11");
    rd(9'h010, "R11");
    rd(9'h104, "R9");
    wr(9'h010, 32'hFFFF_FFFF);
    rd(9'h010, "R11");
    rd(9'h1F0, "R11");
    wr(9'h10C, 32'h0000_0FFF);
    rd(9'h10C, "R9");
    rd(9'hC8, "R3");
    wr(9'h48, 32'hA000_0001);
    rd(9'h118, "R6");
    for (int i = 2; i <= 5; i++) wr(9'h48, 32'hA000_0000 + 32'(i));
    rd(9'h88, "R2");
    rd(9'hC8, "R4");
    rd(9'h48, "R1");
    rd(9'h100, "R7");
    rd(9'h88, "R2");
    for (int i = 0; i < 3; i++) rd(9'h48, "R1");
    rd(9'h48, "R5");
    rd(9'hC8, "R5");
    rd(9'h100, "R5");
    wr(9'h100, 32'h0);
    rd(9'h100, "R8");
    wr(9'h100, 32'h0000_0010);
    rd(9'h100, "R8");
    wr(9'h108, 32'hFFFF_FFFF);
    rd(9'h108, "R8");
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      int b = $urandom_range(0, 5);
      int u = $urandom_range(0, 3);
      logic [8:0] a;
      case (k)
        0, 1, 2: wr(9'h40 + 9'(4*b), $urandom());
        3, 4:    begin a = 9'h40 + 9'(4*b); rd(a, req_of(a)); end
        5:       begin a = 9'h80 + 9'(4*b); rd(a, req_of(a)); end
        6:       begin a = 9'hC0 + 9'(4*b); rd(a, req_of(a)); end
        7:       wr(9'h100 + 9'(8*u), $urandom());
        8:       wr(9'h104 + 9'(8*u), $urandom());
        default: begin a = 9'h100 + 9'(8*u) + ($urandom_range(0,1) ? 9'h4 : 9'h0); rd(a, req_of(a)); end
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule